// File: doc/BRIEF.md
# Multi-Pattern Parallel Test Generator

This block feeds a serializing transmitter with a fresh test word on every enabled clock cycle. The word width is a parameter, and each word carries the next W bits of one continuous test stream. Bit 0 of a word goes out on the line first, so the serialized stream runs on across word boundaries without a seam.

A three-bit select input picks the pattern while the block is running. Four selections give pseudo-random binary sequences of orders 7, 15, 23 and 31. Two give square waves: a fast one that toggles every bit and a slow one whose twenty-bit period does not divide the word width. The receive-side checker has its own selection, so this block's select is the only thing that sets what is transmitted.

A change of select restarts the chosen pattern from its defined start. The enable input freezes the output word and all internal state.

Top module: `ptgen_top`

## Requirements
- R1: While `rst` is high at a clock edge, `tx_word` becomes all zeros and the generator state returns to its start (every shift register bit 1, both square-wave phases 0). The first enabled word after reset starts each pattern from its beginning.
- R2: Select encodings are 0 = PRBS order 7, 1 = PRBS order 15, 2 = PRBS order 23, 3 = PRBS order 31, 4 = toggle pattern and 5 = twenty-bit square wave.
- R3: `tx_word[0]` is the earliest bit of the stream and `tx_word[W-1]` the latest. Successive enabled words carry consecutive stream bits with no gap or repeat.
- R4: A sequence of order N with feedback tap K uses the pairs (7,6), (15,14), (23,18) and (31,28). Each step forms f = s[N-1] xor s[K-1], emits f as the next stream bit and shifts to s = {s[N-2:0], f}. The register is seeded with all ones and never holds all zeros.
- R5: The toggle pattern emits 1, 0, 1, 0, … starting with 1 at restart, and keeps its phase across words when W is odd.
- R6: The twenty-bit square wave emits ten ones then ten zeros, starting with the ones at restart. Its phase runs continuously across words for any W.
- R7: While `en` is low, `tx_word` and all generator state hold. When `en` returns, the stream resumes exactly where it stopped.
- R8: On an enabled cycle whose select differs from the select of the last enabled cycle (0 after reset), the chosen pattern restarts from its start state. A select change made while `en` is low takes effect at the next enabled cycle.
- R9: Select encodings 6 and 7 produce an all-zero word.
- R10: The word is registered: the word for an enabled edge appears on `tx_word` immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; low freezes output and state |
| pat_sel | input | 3 | Pattern select (encodings in R2, R9) |
| tx_word | output | W | Parallel test word, bit 0 sent first |

## Verification
A pattern change and an enable pause can meet in the same cycle. When the select moves while `en` is low, the output must stay frozen, and the restart must happen only on the next enabled edge. The bench provokes this by changing the select during a pause and during reset. It compares every word against a bit-serial reference model that applies the restart rule on its own. Long runs past the 127-bit period of the shortest sequence and across many twenty-bit periods check that the stream stays continuous.

// File: rtl/ptgen_pkg.sv
package ptgen_pkg;

    localparam int LFSR_MAX = 31;
    localparam int PH10_LEN = 20;
    localparam int PH10_W   = 5;
    localparam int NUM_PRBS = 4;

    typedef enum logic [2:0] {
        PAT_PRBS7   = 3'd0,
        PAT_PRBS15  = 3'd1,
        PAT_PRBS23  = 3'd2,
        PAT_PRBS31  = 3'd3,
        PAT_TOGGLE  = 3'd4,
        PAT_SQ20    = 3'd5,
        PAT_NONE6   = 3'd6,
        PAT_NONE7   = 3'd7
    } pat_e;

    typedef struct packed {
        logic [LFSR_MAX-1:0] lfsr;
        logic                ph2;
        logic [PH10_W-1:0]   ph10;
    } gen_state_t;

    localparam gen_state_t GEN_SEED = '{lfsr: '1, ph2: 1'b0, ph10: '0};

    function automatic int prbs_order(input int idx);
        case (idx)
            0: return 7;
            1: return 15;
            2: return 23;
            default: return 31;
        endcase
    endfunction

    function automatic int prbs_tap(input int idx);
        case (idx)
            0: return 6;
            1: return 14;
            2: return 18;
            default: return 28;
        endcase
    endfunction

    function automatic logic is_prbs(input logic [2:0] sel);
        return (sel <= 3'd3);
    endfunction

endpackage

// File: rtl/ptgen_prbs_unroll.sv
module ptgen_prbs_unroll #(
    parameter int ORDER = 7,
    parameter int TAP   = 6,
    parameter int W     = 32
) (
    input  logic [ORDER-1:0] s_in,
    output logic [W-1:0]     bits,
    output logic [ORDER-1:0] s_out
);
    logic [ORDER-1:0] s;
    logic             fb;

    // Unrolled Fibonacci shift: W steps per call, bit 0 earliest.
    always_comb begin
        s    = s_in;
        fb   = 1'b0;
        bits = '0;
        for (int i = 0; i < W; i++) begin
            fb      = s[ORDER-1] ^ s[TAP-1];
            bits[i] = fb;
            s       = {s[ORDER-2:0], fb};
        end
        s_out = s;
    end
endmodule

// File: rtl/ptgen_clk_pattern.sv
module ptgen_clk_pattern
    import ptgen_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              ph2,
    input  logic [PH10_W-1:0] ph10,
    output logic [W-1:0]      w_toggle,
    output logic [W-1:0]      w_sq20,
    output logic              ph2_nx,
    output logic [PH10_W-1:0] ph10_nx
);
    localparam logic ODD_W = ((W % 2) == 1);

    logic [PH10_W-1:0] p;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            w_toggle[i] = ~(ph2 ^ (i % 2 == 1));
        end
        ph2_nx = ph2 ^ ODD_W;
    end

    // Walk the twenty-step phase bit by bit so it carries across words.
    always_comb begin
        p      = ph10;
        w_sq20 = '0;
        for (int i = 0; i < W; i++) begin
            w_sq20[i] = (p < PH10_W'(PH10_LEN / 2));
            p = (p == PH10_W'(PH10_LEN - 1)) ? '0 : p + 1'b1;
        end
        ph10_nx = p;
    end
endmodule

// File: rtl/ptgen_top.sv
module ptgen_top
    import ptgen_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [2:0]   pat_sel,
    output logic [W-1:0] tx_word
);
    gen_state_t st_q, st_start, st_nx;
    logic [2:0] sel_q;
    logic       restart;
    logic [W-1:0] word_nx;

    logic [W-1:0]          prbs_bits [NUM_PRBS];
    logic [LFSR_MAX-1:0]   prbs_nx   [NUM_PRBS];
    logic [W-1:0]          w_toggle, w_sq20;
    logic                  ph2_nx;
    logic [PH10_W-1:0]     ph10_nx;

    assign restart  = (pat_sel != sel_q);
    assign st_start = restart ? GEN_SEED : st_q;

    for (genvar g = 0; g < NUM_PRBS; g++) begin : g_prbs
        localparam int N = prbs_order(g);
        localparam int K = prbs_tap(g);
        logic [N-1:0] nx_slice;
        ptgen_prbs_unroll #(.ORDER(N), .TAP(K), .W(W)) u_unroll (
            .s_in  (st_start.lfsr[N-1:0]),
            .bits  (prbs_bits[g]),
            .s_out (nx_slice)
        );
        assign prbs_nx[g] = LFSR_MAX'(nx_slice);
    end

    ptgen_clk_pattern #(.W(W)) u_clk (
        .ph2      (st_start.ph2),
        .ph10     (st_start.ph10),
        .w_toggle (w_toggle),
        .w_sq20   (w_sq20),
        .ph2_nx   (ph2_nx),
        .ph10_nx  (ph10_nx)
    );

    always_comb begin
        st_nx   = st_start;
        word_nx = '0;
        case (pat_e'(pat_sel))
            PAT_PRBS7:  begin word_nx = prbs_bits[0]; st_nx.lfsr = prbs_nx[0]; end
            PAT_PRBS15: begin word_nx = prbs_bits[1]; st_nx.lfsr = prbs_nx[1]; end
            PAT_PRBS23: begin word_nx = prbs_bits[2]; st_nx.lfsr = prbs_nx[2]; end
            PAT_PRBS31: begin word_nx = prbs_bits[3]; st_nx.lfsr = prbs_nx[3]; end
            PAT_TOGGLE: begin word_nx = w_toggle;     st_nx.ph2  = ph2_nx;     end
            PAT_SQ20:   begin word_nx = w_sq20;       st_nx.ph10 = ph10_nx;    end
            default:    begin word_nx = '0;                                    end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= GEN_SEED;
            sel_q   <= '0;
            tx_word <= '0;
        end else if (en) begin
            st_q    <= st_nx;
            sel_q   <= pat_sel;
            tx_word <= word_nx;
        end
    end

    function automatic logic alternates(input logic [W-1:0] w);
        logic ok;
        ok = 1'b1;
        for (int i = 1; i < W; i++) begin
            if (w[i] == w[i-1]) ok = 1'b0;
        end
        return ok;
    endfunction

    // R7: frozen output while disabled
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(tx_word));

    // R7: frozen state while disabled
    assert_state_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(st_q) && $stable(sel_q));

    // R9: unused encodings give zero words
    assert_unused_zero_R9: assert property (@(posedge clk) disable iff (rst)
        en && (pat_sel >= 3'd6) |=> tx_word == '0);

    // R5: toggle words alternate bit to bit
    assert_toggle_alt_R5: assert property (@(posedge clk) disable iff (rst)
        en && (pat_sel == 3'd4) |=> alternates(tx_word));

    // R5: first toggle bit after a restart is 1
    assert_toggle_start_R5: assert property (@(posedge clk) disable iff (rst)
        en && (pat_sel == 3'd4) && restart |=> tx_word[0]);

    // R6: square-wave phase stays within its period
    assert_phase_range_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> st_q.ph10 < PH10_W'(PH10_LEN));

    // R4: the shift register never locks up at zero
    assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> st_q.lfsr != '0);

    // R8: an enabled cycle leaves the select reference equal to the select
    assert_sel_track_R8: assert property (@(posedge clk) disable iff (rst)
        en |=> sel_q == $past(pat_sel));

    // R8: PRBS restart uses the seed, so the first bit is 1 xor 1 = 0
    assert_prbs_restart_R8: assert property (@(posedge clk) disable iff (rst)
        en && restart && is_prbs(pat_sel) |=> tx_word[0] == 1'b0);
endmodule

// File: tb/ptgen_top_tb.sv
module ptgen_top_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic [2:0]   pat_sel = 3'd0;
    logic [W-1:0] tx_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [W-1:0] exp_q [$];
    string        tag_q [$];

    // model state
    logic [30:0]  m_lfsr = '1;
    int           m_idx  = 0;
    logic [2:0]   m_sel  = 3'd0;
    logic [W-1:0] m_word = '0;

    always #2.5 clk = ~clk;

    ptgen_top #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .pat_sel(pat_sel), .tx_word(tx_word)
    );

    function automatic logic model_bit(input logic [2:0] sel);
        int n, k;
        logic f;
        case (sel)
            3'd0: begin n = 7;  k = 6;  end
            3'd1: begin n = 15; k = 14; end
            3'd2: begin n = 23; k = 18; end
            default: begin n = 31; k = 28; end
        endcase
        if (sel <= 3'd3) begin
            f = m_lfsr[n-1] ^ m_lfsr[k-1];
            m_lfsr = {m_lfsr[29:0], f};
            return f;
        end else if (sel == 3'd4) begin
            f = (m_idx % 2 == 0);
            m_idx++;
            return f;
        end else if (sel == 3'd5) begin
            f = ((m_idx % 20) < 10);
            m_idx++;
            return f;
        end
        return 1'b0;
    endfunction

    task automatic step(input logic r, input logic e, input logic [2:0] s, input string tag);
        @(negedge clk);
        rst = r; en = e; pat_sel = s;
        if (r) begin
            m_lfsr = '1; m_idx = 0; m_sel = 3'd0; m_word = '0;
        end else if (e) begin
            if (s != m_sel) begin
                m_lfsr = '1; m_idx = 0;
            end
            for (int i = 0; i < W; i++) m_word[i] = model_bit(s);
            m_sel = s;
        end
        exp_q.push_back(m_word);
        tag_q.push_back(tag);
    endtask

    task automatic run(input int n, input logic e, input logic [2:0] s, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, e, s, tag);
    endtask

    // monitor: compare each word just after the edge that produced it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [W-1:0] ex;
                string tg;
                ex = exp_q.pop_front();
                tg = tag_q.pop_front();
                n_cmp++;
                if (tx_word !== ex) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", tg, tx_word, ex);
                end
            end
        end
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 3'd0, "R1 reset word zero");
        run(1, 1'b1, 3'd0, "R10 R1 first word after reset");
        run(20, 1'b1, 3'd0, "R4 R3 PRBS order 7 continuity");
        run(6, 1'b1, 3'd1, "R8 R2 PRBS order 15");
        run(6, 1'b1, 3'd2, "R8 R2 PRBS order 23");
        run(8, 1'b1, 3'd3, "R8 R2 PRBS order 31");
        run(5, 1'b1, 3'd4, "R5 toggle pattern");
        run(12, 1'b1, 3'd5, "R6 R3 square wave across words");
        run(4, 1'b0, 3'd5, "R7 hold while disabled");
        run(6, 1'b1, 3'd5, "R7 resume after hold");
        run(3, 1'b1, 3'd6, "R9 select 6 zero");
        run(3, 1'b1, 3'd7, "R9 select 7 zero");
        run(4, 1'b1, 3'd5, "R8 restart after unused");
        run(3, 1'b0, 3'd0, "R7 R8 select change while disabled");
        run(5, 1'b1, 3'd0, "R8 restart on re-enable");
        run(2, 1'b1, 3'd3, "R8 PRBS31 before reset");
        step(1'b1, 1'b1, 3'd3, "R1 reset mid-run");
        run(4, 1'b1, 3'd3, "R1 R10 restart from seed after reset");
        run(2, 1'b0, 3'd3, "R7 hold PRBS31");
        run(4, 1'b1, 3'd3, "R7 resume PRBS31");
        run(3, 1'b1, 3'd4, "R5 toggle again");
        step(1'b0, 1'b0, 3'd4, "R7 final hold");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule